// File: doc/BRIEF.md
# Error Interrupt Aggregator with Data Timeout

This block gathers the error and event conditions raised by the transfer engine of a serial port running in SD/MMC mode. Each condition arrives as a one-cycle strobe. The block latches it into a sticky status bit. A per-source enable mask decides which latched bits drive a level interrupt. When the first enabled condition appears, the block sends a one-cycle terminate pulse to the DMA engine, which aborts the transfer in flight.

The block also holds the data-timeout counter. A free-running prescaler divides the reference clock by 4096. A second counter counts those units while the data phase is active, and it restarts on every data-activity strobe. When it reaches the programmed limit, the block sets the data-timeout status bit exactly as if that condition had been strobed.

Software reaches the block through a small word-wide register port with four addresses. One address reads the status. One holds the enable mask. One is a write-one-to-clear alias of the status. One holds the timeout limit.

Top module: `err_irq_hub`

## Requirements
- R1: After reset the status is 0x00, the enable mask is 0x7F (every source except bit 7 enabled), the timeout limit is 0x4240, and `irq` and `dma_term` are low.
- R2: Status bit positions are: 0 response error, 1 response timeout, 2 data CRC, 3 data timeout, 4 receive timeout, 5 FIFO overrun, 6 FIFO underrun, 7 SDIO event. A strobe on `cond_strobe[i]` sets status bit i at the next clock edge, even when enable bit i is 0. The bit then stays set until it is cleared.
- R3: `irq` is high exactly while at least one status bit is set whose enable bit is also set.
- R4: A write to address 2 clears every status bit written as 1 and leaves the bits written as 0 unchanged. A read of address 0 or address 2 returns the status in bits 7:0.
- R5: When a strobe and a clear of the same bit fall in the same cycle, the strobe wins and the bit remains set.
- R6: `dma_term` is a one-cycle pulse that is issued in the first cycle `irq` is high after a cycle in which it was low. It is not repeated while `irq` stays high.
- R7: The enable mask is written and read at address 1, bits 7:0. Changing the mask changes `irq` in the cycle after the write, and it does not alter any status bit.
- R8: While `data_active` is high with no data-activity strobe, status bit 3 is set after limit × 4096 reference clocks. The limit is written and read at address 3, bits 15:0.
- R9: A pulse on `data_strobe` restarts the timeout count from zero.
- R10: No timeout is flagged while `data_active` is low, or while the limit is 0.
- R11: A write to address 0 has no effect on the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cond_strobe | input | 8 | One-cycle condition strobes from the transfer engine, one per status bit |
| data_active | input | 1 | High while the data phase of a transfer is in progress |
| data_strobe | input | 1 | One-cycle pulse on each data transfer activity; restarts the timeout |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address: 0 status, 1 enable, 2 clear alias, 3 timeout |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Level interrupt: any enabled status bit is set |
| dma_term | output | 1 | One-cycle pulse telling the DMA engine to abort the current transfer |

## Verification
The risky collision is a condition strobe landing in the same cycle as a clear-alias write that names the same bit. The bench provokes it by raising the strobe and the clear write on the same falling edge. After the next rising edge it reads the status back: the collided bit must still be set, while a second bit cleared in the same write must be gone. A similar overlap lives in the timer, where a data-activity strobe arriving partway through the count must push the expiry one full period later. The bench judges this by sampling the status bit just after the original deadline and again after the shifted one.

// File: rtl/eih_pkg.sv
package eih_pkg;

  localparam int NUM_SRC = 8;

  localparam int SRC_RESP_ERR  = 0;
  localparam int SRC_RESP_TMO  = 1;
  localparam int SRC_DATA_CRC  = 2;
  localparam int SRC_DATA_TMO  = 3;
  localparam int SRC_RECV_TMO  = 4;
  localparam int SRC_FIFO_OVR  = 5;
  localparam int SRC_FIFO_UND  = 6;
  localparam int SRC_SDIO      = 7;

  typedef enum logic [1:0] {
    A_STATUS  = 2'd0,
    A_ENABLE  = 2'd1,
    A_CLEAR   = 2'd2,
    A_TIMEOUT = 2'd3
  } eih_addr_e;

  typedef logic [NUM_SRC-1:0] src_vec_t;

  // Sticky update: set bits win over cleared bits.
  function automatic src_vec_t f_next_status(input src_vec_t cur,
                                             input src_vec_t set,
                                             input src_vec_t clr);
    return (cur & ~clr) | set;
  endfunction

  // Combined interrupt request from status and mask.
  function automatic logic f_any_enabled(input src_vec_t st, input src_vec_t en);
    return |(st & en);
  endfunction

endpackage

// File: rtl/eih_regif.sv
module eih_regif
  import eih_pkg::*;
#(
  parameter int       DW        = 32,
  parameter int       TMO_W     = 16,
  parameter logic [TMO_W-1:0]   TMO_RESET = 16'h4240,
  parameter logic [NUM_SRC-1:0] EN_RESET  = 8'h7F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  input  src_vec_t         status,
  output logic [DW-1:0]    reg_rdata,
  output src_vec_t         enable,
  output src_vec_t         clr_mask,
  output logic [TMO_W-1:0] tmo_limit
);

  eih_addr_e addr;
  logic      wr_en_reg, wr_tmo_reg, wr_clr_reg;

  assign addr       = eih_addr_e'(reg_addr);
  assign wr_en_reg  = reg_wr && (addr == A_ENABLE);
  assign wr_tmo_reg = reg_wr && (addr == A_TIMEOUT);
  assign wr_clr_reg = reg_wr && (addr == A_CLEAR);

  assign clr_mask = wr_clr_reg ? reg_wdata[NUM_SRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable    <= EN_RESET;
      tmo_limit <= TMO_RESET;
    end else begin
      if (wr_en_reg)  enable    <= reg_wdata[NUM_SRC-1:0];
      if (wr_tmo_reg) tmo_limit <= reg_wdata[TMO_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (addr)
      A_STATUS,
      A_CLEAR:   reg_rdata[NUM_SRC-1:0] = status;
      A_ENABLE:  reg_rdata[NUM_SRC-1:0] = enable;
      A_TIMEOUT: reg_rdata[TMO_W-1:0]   = tmo_limit;
      default:   reg_rdata = '0;
    endcase
  end

  AST_ENABLE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_reg |=> (enable == $past(reg_wdata[NUM_SRC-1:0]))); // R7

  AST_LIMIT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tmo_reg |=> (tmo_limit == $past(reg_wdata[TMO_W-1:0]))); // R8

endmodule

// File: rtl/eih_status_bank.sv
module eih_status_bank
  import eih_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t set_vec,
  input  src_vec_t clr_mask,
  output src_vec_t status
);

  src_vec_t nxt;

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= nxt[i];
      end
      assign status[i] = bit_q;
    end
  endgenerate

  always_comb nxt = f_next_status(status, set_vec, clr_mask);

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(status & ~clr_mask)) == $past(status & ~clr_mask))); // R2

  AST_STROBE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((status & $past(set_vec)) == $past(set_vec))); // R5

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_mask & ~set_vec)) |=> ((status & $past(clr_mask & ~set_vec)) == '0)); // R4

endmodule

// File: rtl/eih_timeout.sv
module eih_timeout #(
  parameter int TMO_W = 16,
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_active,
  input  logic             data_strobe,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             expire
);

  logic [PRE_W-1:0] pre_q;
  logic [TMO_W-1:0] unit_q;
  logic             unit_tick;
  logic             restart;

  function automatic logic f_reached(input logic [TMO_W-1:0] units,
                                     input logic [TMO_W-1:0] limit);
    return ((TMO_W+1)'(units) + (TMO_W+1)'(1)) >= (TMO_W+1)'(limit);
  endfunction

  assign unit_tick = (pre_q == {PRE_W{1'b1}});
  assign expire    = data_active && !data_strobe && (tmo_limit != '0) &&
                     unit_tick && f_reached(unit_q, tmo_limit);
  assign restart   = !data_active || data_strobe || expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      unit_q <= '0;
    end else if (restart) begin
      pre_q  <= '0;
      unit_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
      if (unit_tick) unit_q <= unit_q + 1'b1;
    end
  end

  AST_NO_EXPIRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_active || tmo_limit == '0) |-> !expire); // R10

  AST_EXPIRE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire); // R8

  AST_STROBE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    data_strobe |=> (pre_q == '0 && unit_q == '0)); // R9

endmodule

// File: rtl/eih_term_gen.sv
module eih_term_gen
  import eih_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t status,
  input  src_vec_t enable,
  output logic     irq,
  output logic     dma_term
);

  logic irq_d;

  assign irq      = f_any_enabled(status, enable);
  assign dma_term = irq && !irq_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_d <= 1'b0;
    else        irq_d <= irq;
  end

  AST_TERM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_term |=> !dma_term); // R6

  AST_TERM_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && $past(irq)) |-> !dma_term); // R6

endmodule

// File: rtl/err_irq_hub.sv
module err_irq_hub
  import eih_pkg::*;
#(
  parameter int DW    = 32,
  parameter int TMO_W = 16,
  parameter int PRE_W = 12,
  parameter logic [TMO_W-1:0]   TMO_RESET = 16'h4240,
  parameter logic [NUM_SRC-1:0] EN_RESET  = 8'h7F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    cond_strobe,
  input  logic          data_active,
  input  logic          data_strobe,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  output logic          dma_term
);

  src_vec_t         status, enable, clr_mask, set_vec;
  logic [TMO_W-1:0] tmo_limit;
  logic             tmo_expire;

  always_comb begin
    set_vec = cond_strobe;
    set_vec[SRC_DATA_TMO] = cond_strobe[SRC_DATA_TMO] | tmo_expire;
  end

  eih_regif #(
    .DW(DW), .TMO_W(TMO_W), .TMO_RESET(TMO_RESET), .EN_RESET(EN_RESET)
  ) u_regif (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .status(status), .reg_rdata(reg_rdata),
    .enable(enable), .clr_mask(clr_mask), .tmo_limit(tmo_limit)
  );

  eih_status_bank u_status (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_mask(clr_mask),
    .status(status)
  );

  eih_timeout #(.TMO_W(TMO_W), .PRE_W(PRE_W)) u_tmo (
    .clk(clk), .rst_n(rst_n), .data_active(data_active),
    .data_strobe(data_strobe), .tmo_limit(tmo_limit), .expire(tmo_expire)
  );

  eih_term_gen u_term (
    .clk(clk), .rst_n(rst_n), .status(status), .enable(enable),
    .irq(irq), .dma_term(dma_term)
  );

  AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && set_vec == '0) |=> $stable(status)); // R11

  AST_IRQ_FOLLOWS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1 && set_vec == '0 && clr_mask == '0)
      |=> (irq == |($past(status) & $past(reg_wdata[NUM_SRC-1:0])))); // R7

endmodule

// File: tb/sim_err_irq_hub.sv
`timescale 1ns/1ps
module sim_err_irq_hub;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cond_strobe = '0;
  logic        data_active = 1'b0;
  logic        data_strobe = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, dma_term;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  err_irq_hub u0 (
    .clk(clk), .rst_n(rst_n), .cond_strobe(cond_strobe),
    .data_active(data_active), .data_strobe(data_strobe),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .dma_term(dma_term)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic strobe(input logic [7:0] m);
    @(negedge clk);
    cond_strobe = m;
    @(negedge clk);
    cond_strobe = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(2'd0, v); check("R1 status", v, 32'h0);
    rd(2'd1, v); check("R1 enable", v, 32'h7F);
    rd(2'd3, v); check("R1 limit", v, 32'h4240);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 dma_term", {31'b0, dma_term}, 32'h0);
  endtask

  task automatic t_sticky_and_term();
    logic [31:0] v;
    @(negedge clk);
    cond_strobe = 8'h04;
    @(negedge clk);
    cond_strobe = '0;
    check("R6 term pulse", {31'b0, dma_term}, 32'h1);
    check("R3 irq set", {31'b0, irq}, 32'h1);
    @(negedge clk);
    check("R6 term single", {31'b0, dma_term}, 32'h0);
    rd(2'd0, v); check("R2 sticky", v, 32'h04);
    strobe(8'h20);
    check("R6 no retrigger", {31'b0, dma_term}, 32'h0);
    rd(2'd2, v); check("R4 read via alias", v, 32'h24);
  endtask

  task automatic t_disabled_source();
    logic [31:0] v;
    wr(2'd2, 32'hFF);
    check("R3 irq low after clear", {31'b0, irq}, 32'h0);
    strobe(8'h80);
    rd(2'd0, v); check("R2 disabled bit latched", v, 32'h80);
    check("R3 disabled no irq", {31'b0, irq}, 32'h0);
    check("R6 disabled no term", {31'b0, dma_term}, 32'h0);
    wr(2'd1, 32'hFF);
    check("R7 enable raises irq", {31'b0, irq}, 32'h1);
    rd(2'd1, v); check("R7 enable readback", v, 32'hFF);
    wr(2'd1, 32'h7F);
    check("R7 disable drops irq", {31'b0, irq}, 32'h0);
    rd(2'd0, v); check("R7 status unaffected", v, 32'h80);
  endtask

  task automatic t_clear_partial();
    logic [31:0] v;
    strobe(8'h03);
    wr(2'd2, 32'h81);
    rd(2'd0, v); check("R4 partial clear", v, 32'h02);
    wr(2'd0, 32'h00);
    rd(2'd0, v); check("R11 status write ignored", v, 32'h02);
    wr(2'd2, 32'h02);
    rd(2'd0, v); check("R4 full clear", v, 32'h00);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    strobe(8'h01);
    @(negedge clk);
    cond_strobe = 8'h04;
    reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 32'h05;
    @(negedge clk);
    cond_strobe = '0; reg_wr = 1'b0; reg_wdata = '0;
    rd(2'd0, v); check("R5 strobe beats clear", v, 32'h04);
    wr(2'd2, 32'hFF);
  endtask

  task automatic t_timeout();
    logic [31:0] v;
    wr(2'd3, 32'h2);
    rd(2'd3, v); check("R8 limit readback", v, 32'h2);
    @(negedge clk); data_active = 1'b1;
    repeat (8192 - 20) @(negedge clk);
    rd(2'd0, v); check("R8 not yet expired", v, 32'h0);
    repeat (40) @(negedge clk);
    rd(2'd0, v); check("R8 expired sets bit 3", v, 32'h08);
    check("R8 irq from timeout", {31'b0, irq}, 32'h1);
    data_active = 1'b0;
    wr(2'd2, 32'hFF);
  endtask

  task automatic t_restart();
    logic [31:0] v;
    wr(2'd3, 32'h1);
    @(negedge clk); data_active = 1'b1;
    repeat (3000) @(negedge clk);
    data_strobe = 1'b1;
    @(negedge clk); data_strobe = 1'b0;
    repeat (1200) @(negedge clk);
    rd(2'd0, v); check("R9 restart delays expiry", v, 32'h0);
    repeat (3000) @(negedge clk);
    rd(2'd0, v); check("R9 expiry after restart", v, 32'h08);
    data_active = 1'b0;
    wr(2'd2, 32'hFF);
  endtask

  task automatic t_idle_and_zero();
    logic [31:0] v;
    repeat (10000) @(negedge clk);
    rd(2'd0, v); check("R10 idle no timeout", v, 32'h0);
    wr(2'd3, 32'h0);
    @(negedge clk); data_active = 1'b1;
    repeat (10000) @(negedge clk);
    rd(2'd0, v); check("R10 zero limit no timeout", v, 32'h0);
    data_active = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sticky_and_term();
    t_disabled_source();
    t_clear_partial();
    t_collision();
    t_timeout();
    t_restart();
    t_idle_and_zero();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule